// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a single-port synchronous static RAM, 32 bits wide and split into four 8-bit byte lanes. The address, write data and write controls are all captured on the rising clock edge. A write is committed by the block itself at the next edge, so no external write pulse is needed. A read goes through a registered output stage: the word captured at one edge reaches the data output after the following edge. A small burst generator supplies the addresses. Two start strobes load a base address. An advance input then steps through the other three words of the aligned four-word block, in either linear order or interleaved order. An asynchronous output enable masks the data output.

The depth is 2^ADDR_W words. The default is 1024 words so that elaboration stays light, and setting ADDR_W to 16 gives the full 64K-word array. The write decode ranks the controls in a fixed order. The global write covers all four lanes. Otherwise, a lane is written only when its lane select and the write enable are both high. A start from the processor-side strobe always reads. Deselecting through a strobe with the chip select low makes the output stop driving one clock after that access is captured. The sleep input blocks every new access while it is high. It also ends any open burst, so accesses resume only at the next start strobe after sleep is released.

Top module: `sram_pipe_burst`

## Requirements
- R1: The lane write mask is 4'b1111 when wr_all is 1, whatever wr_en and lane_sel are. Otherwise it is lane_sel when wr_en is 1, and 0 when wr_en is 0. Bit i of the mask covers data bits 8*i+7..8*i. Lanes outside the mask keep their contents.
- R2: A read access captured at edge N puts the addressed word on rdata, with rdata_drv high, after edge N+1. The word stays there until the next edge.
- R3: A read of an address, captured at the edge right after a write to that address was captured, returns the newly written data.
- R4: A start on strobe_cpu (with sel=1) is always a read, and the write controls are ignored. It takes precedence over strobe_ctl in the same cycle. A start on strobe_ctl alone reads or writes as R1 decodes.
- R5: With order_linear=1, the k-th advance after a start at base address B accesses the address with bits ADDR_W-1..2 taken from B and low two bits equal to (B[1:0]+k) mod 4.
- R6: With order_linear=0, the k-th advance accesses the same upper bits, with low two bits equal to B[1:0] XOR k.
- R7: burst_adv with no strobe does nothing when no burst is open. With burst_adv and both strobes low, no access is made. The output stops driving after the next edge.
- R8: A strobe with sel=0 is a deselect. It closes the burst, and rdata_drv is low after the edge following the capturing edge. Later advances are ignored until a new start.
- R9: out_en acts without a clock. While it is 0, rdata is 0 and rdata_drv is 0. Raising it again restores the held word.
- R10: While sleep_req is 1, no access is captured and the array contents are kept. The burst is closed, so the first access after release must be a start.
- R11: After reset, rdata_drv is 0, rdata is 0 and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| sleep_req | input | 1 | Blocks new accesses and closes the burst |
| sel | input | 1 | Chip select, sampled along with a strobe |
| strobe_cpu | input | 1 | Start strobe that always reads |
| strobe_ctl | input | 1 | Start strobe that honours the write controls |
| burst_adv | input | 1 | Step to the next address of the open burst |
| order_linear | input | 1 | 1 = linear burst order, 0 = interleaved order |
| addr | input | ADDR_W | Word address loaded by a start |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write enable for the lanes picked by lane_sel |
| wr_all | input | 1 | Global write of all four lanes |
| lane_sel | input | 4 | Per-lane write select |
| out_en | input | 1 | Asynchronous output enable |
| rdata | output | 32 | Read data, 0 when not driving |
| rdata_drv | output | 1 | High while rdata carries a valid word |

## Verification
A wrong lane mask or a wrong burst step shows up as a miscompare on rdata. That happens at the first later read of the corrupted address, or, in a burst, two edges after the faulty step. A fault in the output stage is visible right away, on rdata_drv, one edge after the access: a drive that lingers after a deselect, or that is missing after a read. A read-after-write hazard shows as stale data on the read that directly follows the write.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  // Low two address bits of the k-th burst step.
  function automatic logic [1:0] burst_lo(input logic [1:0] base,
                                          input logic [1:0] step,
                                          input logic       linear);
    return linear ? 2'(base + step) : (base ^ step);
  endfunction

  // Lane write mask: global write first, then enable plus lane select.
  function automatic logic [LANES-1:0] lane_mask(input logic             all_w,
                                                 input logic             en_w,
                                                 input logic [LANES-1:0] lsel);
    if (all_w)     return '1;
    else if (en_w) return lsel;
    else           return '0;
  endfunction
endpackage

// File: rtl/sram_burst_ctr.sv
module sram_burst_ctr #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              clear,
  input  logic              linear,
  input  logic [ADDR_W-1:0] load_addr,
  output logic              active,
  output logic [ADDR_W-1:0] next_addr
);
  import sram_pkg::*;

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic              active_q;
  logic [1:0]        cnt_nx;

  assign cnt_nx = cnt_q + 2'd1;
  assign active = active_q;

  always_comb begin
    if (load) next_addr = load_addr;
    else      next_addr = {base_q[ADDR_W-1:2], burst_lo(base_q[1:0], cnt_nx, linear)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (clear) begin
      active_q <= 1'b0;
    end else if (load) begin
      base_q   <= load_addr;
      cnt_q    <= '0;
      active_q <= 1'b1;
    end else if (step) begin
      cnt_q    <= cnt_nx;
    end
  end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl #(
  parameter int ADDR_W = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sleep_req,
  input  logic                        sel,
  input  logic                        strobe_cpu,
  input  logic                        strobe_ctl,
  input  logic                        burst_adv,
  input  logic                        order_linear,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [sram_pkg::DATA_W-1:0] wdata,
  input  logic                        wr_en,
  input  logic                        wr_all,
  input  logic [sram_pkg::LANES-1:0]  lane_sel,
  output logic                        acc_go,
  output logic                        adv_go,
  output logic                        desel_go,
  output logic                        acc_rd,
  output logic [sram_pkg::LANES-1:0]  acc_wm,
  output logic [ADDR_W-1:0]           acc_addr,
  output logic [sram_pkg::DATA_W-1:0] acc_wd
);
  import sram_pkg::*;

  logic             any_strobe;
  logic             start_go;
  logic             burst_open;
  logic [ADDR_W-1:0] next_addr;
  logic [LANES-1:0] mask_now;

  assign any_strobe = strobe_cpu | strobe_ctl;
  assign start_go   = !sleep_req && sel && any_strobe;
  assign desel_go   = !sleep_req && !sel && any_strobe;
  assign adv_go     = !sleep_req && !any_strobe && burst_adv && burst_open;
  assign acc_go     = start_go | adv_go;
  assign mask_now   = (start_go && strobe_cpu) ? '0 : lane_mask(wr_all, wr_en, lane_sel);

  sram_burst_ctr #(.ADDR_W(ADDR_W)) u_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_go),
    .step     (adv_go),
    .clear    (desel_go | sleep_req),
    .linear   (order_linear),
    .load_addr(addr),
    .active   (burst_open),
    .next_addr(next_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_rd   <= 1'b0;
      acc_wm   <= '0;
      acc_addr <= '0;
      acc_wd   <= '0;
    end else if (acc_go) begin
      acc_rd   <= (mask_now == '0);
      acc_wm   <= mask_now;
      acc_addr <= next_addr;
      acc_wd   <= wdata;
    end else begin
      acc_rd   <= 1'b0;
      acc_wm   <= '0;
    end
  end
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int ADDR_W = 10,
  parameter int WIDTH  = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  din,
  output logic [WIDTH-1:0]  dout
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= din;
  end

  assign dout = cells[addr];
endmodule

// File: rtl/sram_pipe_burst.sv
module sram_pipe_burst #(
  parameter int ADDR_W = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sleep_req,
  input  logic                        sel,
  input  logic                        strobe_cpu,
  input  logic                        strobe_ctl,
  input  logic                        burst_adv,
  input  logic                        order_linear,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [sram_pkg::DATA_W-1:0] wdata,
  input  logic                        wr_en,
  input  logic                        wr_all,
  input  logic [sram_pkg::LANES-1:0]  lane_sel,
  input  logic                        out_en,
  output logic [sram_pkg::DATA_W-1:0] rdata,
  output logic                        rdata_drv
);
  import sram_pkg::*;

  logic              acc_go, adv_go, desel_go;
  logic              acc_rd;
  logic [LANES-1:0]  acc_wm;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] acc_wd;
  logic [DATA_W-1:0] arr_rd;
  logic [DATA_W-1:0] out_q;
  logic              drv;

  sram_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_req   (sleep_req),
    .sel         (sel),
    .strobe_cpu  (strobe_cpu),
    .strobe_ctl  (strobe_ctl),
    .burst_adv   (burst_adv),
    .order_linear(order_linear),
    .addr        (addr),
    .wdata       (wdata),
    .wr_en       (wr_en),
    .wr_all      (wr_all),
    .lane_sel    (lane_sel),
    .acc_go      (acc_go),
    .adv_go      (adv_go),
    .desel_go    (desel_go),
    .acc_rd      (acc_rd),
    .acc_wm      (acc_wm),
    .acc_addr    (acc_addr),
    .acc_wd      (acc_wd)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_lane_array #(.ADDR_W(ADDR_W), .WIDTH(LANE_W)) u_lane (
      .clk (clk),
      .we  (acc_wm[g]),
      .addr(acc_addr),
      .din (acc_wd[g*LANE_W +: LANE_W]),
      .dout(arr_rd[g*LANE_W +: LANE_W])
    );
  end

  // Output register: loaded one edge after the read was captured.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      drv   <= 1'b0;
    end else begin
      drv <= acc_rd;
      if (acc_rd) out_q <= arr_rd;
    end
  end

  assign rdata_drv = out_en && drv;
  assign rdata     = rdata_drv ? out_q : '0;
endmodule

// File: rtl/sram_pipe_burst_chk.sv
module sram_pipe_burst_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep_req,
  input logic              strobe_cpu,
  input logic              wr_en,
  input logic              wr_all,
  input logic              acc_go,
  input logic              adv_go,
  input logic              desel_go,
  input logic              acc_rd,
  input logic [3:0]        acc_wm,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              drv
);
  p_global_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && !strobe_cpu && wr_all) |=> (acc_wm == 4'hF));

  p_write_gated_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && !wr_all && !wr_en) |=> (acc_wm == 4'h0));

  p_drive_from_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    drv |-> $past(acc_rd));

  p_cpu_start_reads_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && strobe_cpu) |=> (acc_rd && acc_wm == 4'h0));

  p_burst_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adv_go |=> (acc_addr[ADDR_W-1:2] == $past(acc_addr[ADDR_W-1:2])));

  p_deselect_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    desel_go |=> ##1 !drv);

  p_sleep_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |=> (!acc_rd && acc_wm == 4'h0));
endmodule

bind sram_pipe_burst sram_pipe_burst_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sleep_req (sleep_req),
  .strobe_cpu(strobe_cpu),
  .wr_en     (wr_en),
  .wr_all    (wr_all),
  .acc_go    (acc_go),
  .adv_go    (adv_go),
  .desel_go  (desel_go),
  .acc_rd    (acc_rd),
  .acc_wm    (acc_wm),
  .acc_addr  (acc_addr),
  .drv       (drv)
);

// File: tb/tb_sram_pipe_burst.sv
module tb_sram_pipe_burst;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic sleep_req, sel, strobe_cpu, strobe_ctl, burst_adv, order_linear;
  logic [AW-1:0] addr;
  logic [31:0] wdata;
  logic wr_en, wr_all;
  logic [3:0] lane_sel;
  logic out_en;
  logic [31:0] rdata;
  logic rdata_drv;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_pipe_burst #(.ADDR_W(AW)) dut (.*);

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;
  string cur_req = "R11";

  // Bench reference state
  logic [31:0] shadow [64];
  bit          m_open;
  logic [AW-1:0] m_base;
  int          m_step;
  bit          p_rd;
  logic [3:0]  p_mask;
  logic [AW-1:0] p_addr;
  logic [31:0] p_wd;
  bit          e_drv;
  logic [31:0] e_out;

  function automatic logic [1:0] step_lo(logic [1:0] b, int k, bit lin);
    int v;
    if (lin) v = (int'(b) + k) % 4;
    else     v = int'(b) ^ (k % 4);
    return v[1:0];
  endfunction

  function automatic logic [31:0] apply_bytes(logic [31:0] old, logic [31:0] nw, logic [3:0] m);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++)
      if (m[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  function automatic logic [3:0] write_bytes(bit g, bit e, logic [3:0] s);
    if (g == 1'b1) return 4'hF;
    return e ? s : 4'h0;
  endfunction

  task automatic check(string req, bit cond, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (!cond) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    sleep_req = 0; sel = 1; strobe_cpu = 0; strobe_ctl = 0; burst_adv = 0;
    wr_en = 0; wr_all = 0; lane_sel = 0; out_en = 1; wdata = '0;
  endtask

  // Model one edge, apply it, then compare the outputs at the falling edge.
  task automatic tick();
    bit strobe, st, dsl, adv_ok;
    logic [3:0] mk;
    logic [31:0] exp_rd;
    // output stage fed by the access captured at the previous edge
    e_drv = p_rd;
    if (p_rd) e_out = shadow[p_addr[5:0]];
    if (p_mask != 0) shadow[p_addr[5:0]] = apply_bytes(shadow[p_addr[5:0]], p_wd, p_mask);
    strobe = strobe_cpu || strobe_ctl;
    st     = !sleep_req && sel && strobe;
    dsl    = !sleep_req && !sel && strobe;
    adv_ok = !sleep_req && !strobe && burst_adv && m_open;
    p_rd = 0; p_mask = 0;
    if (st || adv_ok) begin
      mk = strobe_cpu ? 4'h0 : write_bytes(wr_all, wr_en, lane_sel);
      if (st) begin
        m_base = addr; m_step = 0; m_open = 1; p_addr = addr;
      end else begin
        m_step = m_step + 1;
        p_addr = {m_base[AW-1:2], step_lo(m_base[1:0], m_step, order_linear)};
      end
      p_mask = mk; p_rd = (mk == 0); p_wd = wdata;
    end
    if (dsl || sleep_req) m_open = 0;
    @(posedge clk);
    @(negedge clk);
    exp_rd = (out_en && e_drv) ? e_out : 32'h0;
    check({cur_req, " drive"}, rdata_drv === (out_en && e_drv), {31'h0, rdata_drv}, {31'h0, out_en && e_drv});
    check({cur_req, " data"}, rdata === exp_rd, rdata, exp_rd);
  endtask

  task automatic go_start(bit cpu, logic [AW-1:0] a, bit we, bit ga, logic [3:0] ls, logic [31:0] d);
    idle();
    strobe_cpu = cpu; strobe_ctl = !cpu; addr = a; wr_en = we; wr_all = ga; lane_sel = ls; wdata = d;
    tick();
  endtask

  task automatic go_adv(bit we, bit ga, logic [3:0] ls, logic [31:0] d);
    idle();
    burst_adv = 1; wr_en = we; wr_all = ga; lane_sel = ls; wdata = d;
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    idle(); addr = '0; order_linear = 1;
    m_open = 0; p_rd = 0; p_mask = 0; e_drv = 0; e_out = 0; p_addr = 0; p_wd = 0; m_base = 0; m_step = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R11: reset state
    check("R11 drive", rdata_drv === 1'b0, {31'h0, rdata_drv}, 32'h0);
    check("R11 data", rdata === 32'h0, rdata, 32'h0);
    // R7: advance with no open burst after reset
    cur_req = "R7"; go_adv(0, 0, 0, 0); tick();

    // Fill the tested region through global writes
    cur_req = "R1";
    for (int a = 0; a < 64; a++) go_start(0, AW'(a), 0, 1, 4'h0, $urandom());
    idle(); tick();

    // R1: lane writes, global write, missing enable
    go_start(0, 5, 1, 0, 4'b0101, 32'hA1B2C3D4);
    go_start(1, 5, 0, 0, 0, 0); idle(); tick();
    go_start(0, 6, 0, 1, 4'b0000, 32'h11223344);
    go_start(1, 6, 0, 0, 0, 0); idle(); tick();
    go_start(0, 6, 0, 0, 4'b1111, 32'hDEADBEEF);
    idle(); tick();
    go_start(0, 4, 1, 0, 4'b1111, 32'h0BADF00D);
    go_start(1, 4, 0, 0, 0, 0); idle(); tick();

    // R3: read right after write to the same address
    cur_req = "R3";
    go_start(0, 7, 0, 1, 0, 32'hCAFE0007);
    go_start(0, 7, 0, 0, 0, 0); idle(); tick();

    // R4: cpu strobe ignores write controls and wins over ctl strobe
    cur_req = "R4";
    idle(); strobe_cpu = 1; strobe_ctl = 1; addr = 8; wr_all = 1; wdata = 32'hFFFFFFFF; tick();
    go_start(1, 8, 0, 0, 0, 0); idle(); tick();

    // R5: linear bursts, read and write
    cur_req = "R5"; order_linear = 1;
    go_start(0, 9, 0, 0, 0, 0);
    for (int k = 0; k < 3; k++) go_adv(0, 0, 0, 0);
    go_start(0, 14, 0, 1, 0, 32'h50000000);
    for (int k = 0; k < 3; k++) go_adv(1, 0, 4'hF, 32'h50000001 + k);
    go_start(1, 12, 0, 0, 0, 0);
    for (int k = 0; k < 3; k++) go_adv(0, 0, 0, 0);
    idle(); tick();

    // R6: interleaved bursts
    cur_req = "R6"; order_linear = 0;
    go_start(0, 17, 0, 0, 0, 0);
    for (int k = 0; k < 3; k++) go_adv(0, 0, 0, 0);
    go_start(0, 22, 0, 1, 0, 32'h60000000);
    for (int k = 0; k < 3; k++) go_adv(0, 1, 0, 32'h60000001 + k);
    go_start(1, 20, 0, 0, 0, 0);
    for (int k = 0; k < 3; k++) go_adv(0, 0, 0, 0);
    order_linear = 1;

    // R7: pause inside a burst, then resume
    cur_req = "R7";
    go_start(1, 24, 0, 0, 0, 0);
    idle(); tick(); tick();
    go_adv(0, 0, 0, 0); idle(); tick();

    // R8: deselect closes burst and drops drive
    cur_req = "R8";
    go_start(1, 28, 0, 0, 0, 0);
    go_adv(0, 0, 0, 0);
    idle(); sel = 0; strobe_cpu = 1; addr = 30; tick();
    go_adv(0, 0, 0, 0); go_adv(0, 1, 0, 32'h12345678); idle(); tick();
    go_start(1, 28, 0, 0, 0, 0); idle(); tick();

    // R9: asynchronous output enable
    cur_req = "R9";
    go_start(1, 5, 0, 0, 0, 0);
    idle(); tick();
    out_en = 0; #1;
    check("R9 mask data", rdata === 32'h0, rdata, 32'h0);
    check("R9 mask drive", rdata_drv === 1'b0, {31'h0, rdata_drv}, 32'h0);
    out_en = 1; #1;
    check("R9 restore", rdata === e_out && rdata_drv === 1'b1, rdata, e_out);
    tick();

    // R10: sleep blocks accesses, closes burst, keeps contents
    cur_req = "R10";
    go_start(1, 10, 0, 0, 0, 0);
    idle(); sleep_req = 1; strobe_ctl = 1; addr = 10; wr_all = 1; wdata = 32'h0; tick();
    idle(); sleep_req = 1; burst_adv = 1; tick();
    go_adv(0, 1, 0, 32'h99999999);
    go_start(1, 10, 0, 0, 0, 0); idle(); tick();

    // Random mix; every cycle compared against the reference
    cur_req = "R2";
    for (int n = 0; n < 3000; n++) begin
      idle();
      strobe_cpu   = ($urandom % 8) == 0;
      strobe_ctl   = ($urandom % 5) == 0;
      sel          = ($urandom % 10) != 0;
      burst_adv    = $urandom % 2;
      sleep_req    = ($urandom % 25) == 0;
      wr_all       = ($urandom % 6) == 0;
      wr_en        = ($urandom % 3) == 0;
      lane_sel     = 4'($urandom);
      addr         = AW'($urandom % 64);
      wdata        = $urandom();
      order_linear = $urandom % 2;
      out_en       = ($urandom % 10) != 0;
      tick();
    end
    idle(); tick(); tick();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule